// File: doc/BRIEF.md
# UART Sleep Wakeup Detector

This block watches a sleeping UART and raises a sticky wakeup event when a selected criterion is met. Three criteria are available. The first counts transitions on the receive line. The second counts bytes that the UART core reports as received. The third looks for an ordered sequence of configured wake characters, and individual positions in that sequence can be set to accept any byte. A fourth mode code turns detection off.

The raw receive line enters through a two-flop synchronizer, and both rising and falling transitions are counted. Received bytes arrive as a one-cycle strobe with the data alongside. All configuration is presented as static inputs. The event output stays high until it is cleared. Changing the mode, or clearing the event, restarts every counter and the sequence position.

Top module: `uart_wake_detect`

## Requirements
- R1: After reset, wake_evt_o is 0, and the edge count, byte count and sequence position are all zero.
- R2: With mode_i = 0, each level change of rxd_i (either polarity) passes through two synchronizer flops. The change that makes the edge count greater than edge_thresh_i sets wake_evt_o at the third rising clock edge after rxd_i changed. With a threshold of 1023, the 1024th change is the one that wakes.
- R3: With mode_i = 1, the byte_vld_i strobe that makes the received-byte count greater than byte_thresh_i sets wake_evt_o at that same clock edge.
- R4: With mode_i = 2, wake character k is wake_chars_i[8k+7:8k]. The first char_num_i characters must arrive in order from character 0. The strobe that carries the last of them sets wake_evt_o.
- R5: When bit k of char_mask_i is 1, sequence position k accepts any byte.
- R6: A byte that fails to match the current position restarts the sequence. That same byte is then compared with character 0, so a match there moves the position to 1.
- R7: A char_num_i of 0 disables sequence wakeup. A value above 5 behaves as 5. If char_num_i is lowered to or below the current position, the next byte is compared from character 0.
- R8: wake_evt_o stays 1 until evt_clr_i is 1. evt_clr_i clears it at the next clock edge, and it wins over a detection in the same cycle.
- R9: In a cycle where evt_clr_i is 1 or mode_i differs from its value in the previous cycle, all counts and the sequence position return to zero and no detection takes place.
- R10: Only the criterion of the current mode can set the event. Byte strobes do nothing in mode 0, receive-line changes do nothing in modes 1 and 2, and mode 3 never wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Raw receive line level |
| byte_vld_i | input | 1 | One-cycle strobe for a received byte |
| byte_data_i | input | 8 | Received byte |
| mode_i | input | 2 | 0 edges, 1 byte count, 2 character sequence, 3 off |
| edge_thresh_i | input | 10 | Edge count that must be exceeded |
| byte_thresh_i | input | 5 | Byte count that must be exceeded |
| char_num_i | input | 3 | Number of wake characters in use |
| char_mask_i | input | 5 | Per-position wildcard bits |
| wake_chars_i | input | 40 | Wake characters, character k in bits 8k+7:8k |
| evt_clr_i | input | 1 | Clears the event, the counts and the sequence position |
| wake_evt_o | output | 1 | Sticky wakeup event |

## Verification
The bench builds the block with its default parameters: a 10-bit edge threshold, a 5-bit byte threshold, five 8-bit wake characters and two synchronizer stages. During the random phase it keeps the thresholds small and draws the bytes from a small alphabet, so that wakeups, partial sequence matches and restarts after a mismatch all happen often. A 3-bit character count with five positions allows the clamp above five to be driven. The full 10-bit edge threshold takes only about a thousand cycles to reach by toggling the receive line every cycle, so the 1024th-edge boundary is tested directly.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [1:0] {
    WK_EDGE = 2'd0,
    WK_BYTE = 2'd1,
    WK_SEQ  = 2'd2,
    WK_OFF  = 2'd3
  } wake_mode_e;
endpackage

// File: rtl/uart_wake_rxd_edge.sv
module uart_wake_rxd_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic edge_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // idle line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      last_q <= sync_q[MSB];
    end
  end

  assign edge_o = sync_q[MSB] ^ last_q;
endmodule

// File: rtl/uart_wake_thresh_cnt.sv
module uart_wake_thresh_cnt #(
  parameter int unsigned TH_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            inc_i,
  input  logic [TH_W-1:0] thresh_i,
  output logic            hit_o
);
  // one extra bit so that "count > max threshold" is representable
  localparam int unsigned CNT_W = TH_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = en_i & inc_i & ~clr_i;
  // new count = cnt_q + 1 exceeds thresh  <=>  cnt_q >= thresh
  assign hit_o = step & (cnt_q >= {1'b0, thresh_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (step && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  // R9
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  // R9
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/uart_wake_char_seq.sv
module uart_wake_char_seq #(
  parameter int unsigned NUM_CHARS = 5,
  parameter int unsigned CHAR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        en_i,
  input  logic                        byte_vld_i,
  input  logic [CHAR_W-1:0]           byte_i,
  input  logic [NUM_CHARS*CHAR_W-1:0] chars_i,
  input  logic [$clog2(NUM_CHARS+1)-1:0] num_i,
  input  logic [NUM_CHARS-1:0]        mask_i,
  output logic                        hit_o
);
  localparam int unsigned IDX_W = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
  localparam int unsigned NUM_W = $clog2(NUM_CHARS + 1);

  logic [NUM_CHARS-1:0] pos_ok;
  logic [NUM_W-1:0]     used;
  logic [IDX_W-1:0]     idx_q, idx_d, eff_idx;
  logic                 step, cur_ok, last;

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_pos
    assign pos_ok[k] = mask_i[k] | (chars_i[k*CHAR_W +: CHAR_W] == byte_i);
  end

  always_comb begin
    used    = (num_i > NUM_W'(NUM_CHARS)) ? NUM_W'(NUM_CHARS) : num_i;
    // a position left stale by a lowered count restarts at char 0
    eff_idx = (int'(idx_q) >= int'(used)) ? '0 : idx_q;
    last    = (int'(eff_idx) + 1 == int'(used));
    cur_ok  = pos_ok[eff_idx];
    step    = en_i & byte_vld_i & ~clr_i & (used != '0);
    hit_o   = step & cur_ok & last;

    idx_d = idx_q;
    if (clr_i)            idx_d = '0;
    else if (step) begin
      if (cur_ok)         idx_d = last ? '0 : IDX_W'(int'(eff_idx) + 1);
      else if (pos_ok[0]) idx_d = IDX_W'(1);
      else                idx_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < int'(NUM_CHARS));

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !cur_ok) |=> (idx_q <= IDX_W'(1)));
endmodule

// File: rtl/uart_wake_detect.sv
module uart_wake_detect
  import uart_wake_pkg::*;
#(
  parameter int unsigned EDGE_TH_W   = 10,
  parameter int unsigned BYTE_TH_W   = 5,
  parameter int unsigned NUM_CHARS   = 5,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rxd_i,
  input  logic                           byte_vld_i,
  input  logic [CHAR_W-1:0]              byte_data_i,
  input  logic [1:0]                     mode_i,
  input  logic [EDGE_TH_W-1:0]           edge_thresh_i,
  input  logic [BYTE_TH_W-1:0]           byte_thresh_i,
  input  logic [$clog2(NUM_CHARS+1)-1:0] char_num_i,
  input  logic [NUM_CHARS-1:0]           char_mask_i,
  input  logic [NUM_CHARS*CHAR_W-1:0]    wake_chars_i,
  input  logic                           evt_clr_i,
  output logic                           wake_evt_o
);
  wake_mode_e mode, mode_q;
  logic       mode_chg, clr, rxd_edge;
  logic       edge_hit, byte_hit, seq_hit;
  logic       evt_q;

  assign mode     = wake_mode_e'(mode_i);
  assign mode_chg = (mode != mode_q);
  assign clr      = evt_clr_i | mode_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= WK_EDGE;
    else         mode_q <= mode;
  end

  uart_wake_rxd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .edge_o (rxd_edge)
  );

  uart_wake_thresh_cnt #(.TH_W(EDGE_TH_W)) u_edge_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .en_i     (mode == WK_EDGE),
    .inc_i    (rxd_edge),
    .thresh_i (edge_thresh_i),
    .hit_o    (edge_hit)
  );

  uart_wake_thresh_cnt #(.TH_W(BYTE_TH_W)) u_byte_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .en_i     (mode == WK_BYTE),
    .inc_i    (byte_vld_i),
    .thresh_i (byte_thresh_i),
    .hit_o    (byte_hit)
  );

  uart_wake_char_seq #(.NUM_CHARS(NUM_CHARS), .CHAR_W(CHAR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .en_i       (mode == WK_SEQ),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_data_i),
    .chars_i    (wake_chars_i),
    .num_i      (char_num_i),
    .mask_i     (char_mask_i),
    .hit_o      (seq_hit)
  );

  // clear wins over a same-cycle detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            evt_q <= 1'b0;
    else if (evt_clr_i)                     evt_q <= 1'b0;
    else if (edge_hit | byte_hit | seq_hit) evt_q <= 1'b1;
  end

  assign wake_evt_o = evt_q;

  // R8
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_evt_o && !evt_clr_i) |=> wake_evt_o);

  // R8
  evt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr_i |=> !wake_evt_o);

  // R10
  off_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == WK_OFF) |=> !$rose(wake_evt_o));

  // R9
  chg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !$rose(wake_evt_o));
endmodule

// File: tb/sim_uart_wake_detect.sv
module sim_uart_wake_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic        bv = 1'b0;
  logic [7:0]  bd = '0;
  logic [1:0]  mode = 2'd0;
  logic [9:0]  eth = 10'd3;
  logic [4:0]  bth = 5'd2;
  logic [2:0]  num = 3'd5;
  logic [4:0]  mask = '0;
  logic [39:0] chars = {8'h45, 8'h44, 8'h43, 8'h42, 8'h41};
  logic        evt_clr = 1'b0;
  logic        evt;

  int nchk = 0;
  int nfail = 0;

  // reference state
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_p = 1'b1, m_evt = 1'b0;
  logic [1:0] m_mode = 2'd0;
  int m_ecnt = 0, m_bcnt = 0, m_idx = 0;

  always #4 clk = ~clk;

  uart_wake_detect u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rxd_i         (rxd),
    .byte_vld_i    (bv),
    .byte_data_i   (bd),
    .mode_i        (mode),
    .edge_thresh_i (eth),
    .byte_thresh_i (bth),
    .char_num_i    (num),
    .char_mask_i   (mask),
    .wake_chars_i  (chars),
    .evt_clr_i     (evt_clr),
    .wake_evt_o    (evt)
  );

  function automatic logic pos_ok(input int k, input logic [7:0] b);
    return mask[k] || (chars[k*8 +: 8] == b);
  endfunction

  function automatic string mode_req(input logic [1:0] md);
    case (md)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic edg, clr, hit;
    int used, e;
    edg  = (m_s2 != m_p);
    clr  = evt_clr || (mode != m_mode);
    hit  = 1'b0;
    used = (num > 3'd5) ? 5 : int'(num);
    if (clr) begin
      m_ecnt = 0; m_bcnt = 0; m_idx = 0;
    end else begin
      case (mode)
        2'd0: if (edg) begin
          if (m_ecnt >= int'(eth)) hit = 1'b1;
          if (m_ecnt < 2047) m_ecnt++;
        end
        2'd1: if (bv) begin
          if (m_bcnt >= int'(bth)) hit = 1'b1;
          if (m_bcnt < 63) m_bcnt++;
        end
        2'd2: if (bv && used != 0) begin
          e = (m_idx >= used) ? 0 : m_idx;
          if (pos_ok(e, bd)) begin
            if (e + 1 == used) begin hit = 1'b1; m_idx = 0; end
            else m_idx = e + 1;
          end else m_idx = pos_ok(0, bd) ? 1 : 0;
        end
        default: ;
      endcase
    end
    m_p = m_s2; m_s2 = m_s1; m_s1 = rxd;
    m_mode = mode;
    if (evt_clr) m_evt = 1'b0;
    else if (hit) m_evt = 1'b1;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(evt, m_evt, mode_req(mode));
  endtask

  task automatic send_byte(input logic [7:0] b);
    bv = 1'b1; bd = b; cyc();
    bv = 1'b0; cyc();
  endtask

  task automatic toggle();
    rxd = ~rxd;
    repeat (3) cyc();
  endtask

  task automatic clear_evt();
    evt_clr = 1'b1; cyc();
    evt_clr = 1'b0; cyc();
  endtask

  function automatic logic [7:0] pick();
    case ($urandom_range(0, 3))
      0: return 8'h41;
      1: return 8'h42;
      2: return 8'h43;
      default: return 8'h5A;
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(evt, 1'b0, "R1 reset");

    // R2 edge count with latency
    repeat (3) toggle();
    chk(evt, 1'b0, "R2 three edges at thresh 3");
    rxd = ~rxd; cyc(); cyc();
    chk(evt, 1'b0, "R2 still in synchronizer");
    cyc();
    chk(evt, 1'b1, "R2 fourth edge");

    // R8 sticky and clear
    repeat (5) toggle();
    chk(evt, 1'b1, "R8 sticky");
    clear_evt();
    chk(evt, 1'b0, "R8 cleared");

    // R8 clear wins over detection
    mode = 2'd1; bth = 5'd0; cyc();
    bv = 1'b1; bd = 8'h11; evt_clr = 1'b1; cyc();
    bv = 1'b0; evt_clr = 1'b0; cyc();
    chk(evt, 1'b0, "R8 clear wins");
    send_byte(8'h22);
    chk(evt, 1'b1, "R1 R3 first byte at thresh 0");
    clear_evt();

    // R3 byte count
    bth = 5'd2;
    send_byte(8'h01); send_byte(8'h02);
    chk(evt, 1'b0, "R3 two bytes");
    send_byte(8'h03);
    chk(evt, 1'b1, "R3 third byte");
    clear_evt();

    // R9 clears
    send_byte(8'h01); send_byte(8'h02);
    clear_evt();
    send_byte(8'h01); send_byte(8'h02);
    chk(evt, 1'b0, "R9 clear zeroes count");
    mode = 2'd0; cyc(); mode = 2'd1; cyc();
    send_byte(8'h01); send_byte(8'h02);
    chk(evt, 1'b0, "R9 mode change zeroes count");
    send_byte(8'h03);
    chk(evt, 1'b1, "R9 count resumes");
    clear_evt();

    // R10 mode isolation
    mode = 2'd3; cyc();
    repeat (4) toggle();
    for (int i = 0; i < 5; i++) send_byte(8'h41 + 8'(i));
    chk(evt, 1'b0, "R10 mode 3 off");
    mode = 2'd0; eth = 10'd0; cyc();
    repeat (4) send_byte(8'h41);
    chk(evt, 1'b0, "R10 bytes ignored in mode 0");
    toggle();
    chk(evt, 1'b1, "R10 R2 single edge at thresh 0");
    clear_evt();
    mode = 2'd1; bth = 5'd0; cyc();
    repeat (3) toggle();
    chk(evt, 1'b0, "R10 edges ignored in mode 1");
    clear_evt();

    // R4 full sequence
    mode = 2'd2; num = 3'd5; mask = '0; cyc();
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h43); send_byte(8'h44);
    chk(evt, 1'b0, "R4 partial");
    send_byte(8'h45);
    chk(evt, 1'b1, "R4 complete");
    clear_evt();

    // R5 wildcards
    num = 3'd3; mask = 5'b00100;
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h5A);
    chk(evt, 1'b1, "R5 wildcard pos2");
    clear_evt();
    mask = 5'b00001;
    send_byte(8'h5A); send_byte(8'h42); send_byte(8'h43);
    chk(evt, 1'b1, "R5 wildcard pos0");
    clear_evt();

    // R6 restart
    mask = '0;
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h41); send_byte(8'h42);
    chk(evt, 1'b0, "R6 restart partial");
    send_byte(8'h43);
    chk(evt, 1'b1, "R6 mismatch byte reused as char0");
    clear_evt();
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h5A); send_byte(8'h43);
    chk(evt, 1'b0, "R6 mismatch breaks sequence");
    clear_evt();

    // R7 count limits
    num = 3'd0;
    for (int i = 0; i < 5; i++) send_byte(8'h41 + 8'(i));
    chk(evt, 1'b0, "R7 count 0 disabled");
    num = 3'd7;
    for (int i = 0; i < 4; i++) send_byte(8'h41 + 8'(i));
    chk(evt, 1'b0, "R7 clamp partial");
    send_byte(8'h45);
    chk(evt, 1'b1, "R7 clamp to five");
    clear_evt();
    num = 3'd5;
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h43);
    num = 3'd2;
    send_byte(8'h41); send_byte(8'h42);
    chk(evt, 1'b1, "R7 lowered count restarts");
    clear_evt();

    // R2 maximum threshold
    mode = 2'd0; eth = 10'd1023; cyc();
    for (int i = 0; i < 1023; i++) begin rxd = ~rxd; cyc(); end
    repeat (4) cyc();
    chk(evt, 1'b0, "R2 1023 edges");
    toggle();
    chk(evt, 1'b1, "R2 1024th edge");
    clear_evt();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 256 == 0) begin
        eth  = 10'($urandom_range(0, 6));
        bth  = 5'($urandom_range(0, 3));
        num  = 3'($urandom_range(0, 7));
        mask = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : '0;
        for (int k = 0; k < 5; k++) chars[k*8 +: 8] = 8'h41 + 8'($urandom_range(0, 2));
      end
      if ($urandom_range(0, 199) == 0) mode = 2'($urandom_range(0, 3));
      evt_clr = ($urandom_range(0, 59) == 0);
      if ($urandom_range(0, 3) == 0) rxd = ~rxd;
      bv = ($urandom_range(0, 2) == 0);
      bd = pick();
      cyc();
    end
    bv = 1'b0; evt_clr = 1'b0;
    cyc();

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule